// File: doc/BRIEF.md
# Ethernet Pause Flow Controller

This block handles MAC-control pause behaviour for a single Ethernet port. On the receive side it accepts the timer value of a pause frame that has already been parsed and validated. It keeps that value in a local countdown. While the countdown is nonzero it raises a transmit-start inhibit. The countdown moves down by one on each pause-quantum tick, and one quantum is 512 bit times. The MAC only looks at the inhibit when it is about to begin a frame. A frame that is already on the wire when a pause arrives therefore finishes normally.

On the transmit side the block decides when the MAC should emit a pause frame. Three sources can ask for one, and each has its own enable. Any combination of them may be on at once.

- **Fill threshold.** The receive-FIFO fill level moves from at-or-below a programmed threshold to above it.
- **Retransmission timer.** The timer runs while the FIFO stays congested after such a threshold pause.
- **External request.** A rising edge on an external request pin asks for a pause regardless of FIFO state.

Each request appears as a one-cycle strobe. The strobe carries the pause value that the outgoing frame should advertise. Building the frame and computing its CRC happen elsewhere.

Top module: `pause_flow_ctrl`

## Requirements
- R1: A cycle with `rxPauseValid` high loads `rxPauseQuanta` into the pause countdown. If that value is nonzero, `txHold` is high from the next cycle on.
- R2: A valid received pause value of zero clears the countdown, so `txHold` is low in the next cycle even if a pause was running.
- R3: The countdown drops by one in each cycle where `quantaTick` is high and the countdown is nonzero. A load of N holds `txHold` high through N-1 ticks, and `txHold` goes low on the cycle after the Nth tick. A load in the same cycle as a tick takes priority over the decrement.
- R4: The fill level counts as above threshold only when `fillLevel > fillThresh`, in unsigned compare, so equal is not above. With `cfgThreshEn` high, moving from not-above to above issues exactly one pause request. Remaining above issues no further threshold requests.
- R5: With both `cfgThreshEn` and `cfgRetxEn` high, a threshold pause arms a retransmission timer. While the fill stays above threshold, a further request follows every `retxInterval` cycles, each interval counted from the previous request. A `retxInterval` of 0 sends no retransmissions.
- R6: When the fill level falls back to at-or-below the threshold, the retransmission timer is cleared and stopped, and no retransmission follows. A later upward crossing issues a fresh threshold request and restarts the interval from zero.
- R7: With `cfgExtEn` high, a rising edge of `extPauseReq` issues exactly one pause request whatever the fill level. Holding the pin high issues no more.
- R8: A source whose enable is low issues no requests. With all three enables low, `pauseSendReq` stays low.
- R9: `pauseSendReq` is a one-cycle strobe registered one cycle after the triggering condition. Triggers from several sources in the same cycle give a single strobe. `pauseSendQuanta` in that strobe cycle equals `cfgSendQuanta` as it was in the triggering cycle.
- R10: During and right after reset, `txHold` and `pauseSendReq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxPauseValid | input | 1 | Strobe: a valid pause frame was received |
| rxPauseQuanta | input | QUANTA_W | Timer value carried by the received pause frame |
| quantaTick | input | 1 | One pulse per 512-bit-time pause quantum |
| fillLevel | input | FILL_W | Current receive-FIFO fill level |
| fillThresh | input | FILL_W | Congestion threshold for the fill level |
| retxInterval | input | IVL_W | Retransmission interval in clock cycles, 0 disables |
| cfgThreshEn | input | 1 | Enable for the fill-threshold trigger |
| cfgRetxEn | input | 1 | Enable for the retransmission trigger |
| cfgExtEn | input | 1 | Enable for the external request trigger |
| extPauseReq | input | 1 | External pause request; its rising edge counts |
| cfgSendQuanta | input | QUANTA_W | Pause value to advertise in sent pause frames |
| txHold | output | 1 | Inhibits the start of a new transmit frame |
| pauseSendReq | output | 1 | One-cycle request to send a pause frame |
| pauseSendQuanta | output | QUANTA_W | Pause value belonging to the request |

## Verification
The assertions check the following on every cycle:

- the one-cycle consequences of pause loads, zero clears and idle cycles on `txHold`;
- the silence of `pauseSendReq` when every source is disabled or inactive;
- the single request that follows an enabled external rising edge;
- the pairing of each request with the value sampled one cycle earlier.

Multi-cycle behaviour can only be shown by the bench's scenarios: exact countdown length, edge-only threshold firing, retransmission spacing, timer cancellation when the fill falls, and the interaction of all triggers. The bench covers these with directed windows where it counts pulses, and with a long random run compared cycle by cycle against an expected model.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  // Strobes from trigger control to the pause datapath
  typedef struct packed {
    logic threshFire;
    logic retxFire;
    logic extFire;
  } pfcStrobes_t;
endpackage

// File: rtl/pfc_trigger_ctl.sv
module pfc_trigger_ctl
  import pfc_pkg::*;
#(
  parameter int FILL_W = 13,
  parameter int IVL_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FILL_W-1:0] fillLevel,
  input  logic [FILL_W-1:0] fillThresh,
  input  logic [IVL_W-1:0]  retxInterval,
  input  logic              cfgThreshEn,
  input  logic              cfgRetxEn,
  input  logic              cfgExtEn,
  input  logic              extPauseReq,
  output pfcStrobes_t       strobes
);
  localparam int CNT_W = IVL_W + 1;

  logic             aboveNow;
  logic             aboveQ;
  logic             extQ;
  logic             retxActive;
  logic [IVL_W-1:0] retxCnt;
  logic [CNT_W-1:0] cntNext;
  logic             intervalDone;

  always_comb begin
    aboveNow     = fillLevel > fillThresh;
    cntNext      = {1'b0, retxCnt} + CNT_W'(1);
    intervalDone = retxActive && aboveNow && (retxInterval != '0) &&
                   (cntNext >= {1'b0, retxInterval});
    strobes.threshFire = cfgThreshEn && aboveNow && !aboveQ;
    strobes.retxFire   = cfgThreshEn && cfgRetxEn && intervalDone;
    strobes.extFire    = cfgExtEn && extPauseReq && !extQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aboveQ     <= 1'b0;
      extQ       <= 1'b0;
      retxActive <= 1'b0;
      retxCnt    <= '0;
    end else begin
      aboveQ <= aboveNow;
      extQ   <= extPauseReq;
      if (!aboveNow) begin
        retxActive <= 1'b0;
        retxCnt    <= '0;
      end else if (strobes.threshFire) begin
        retxActive <= 1'b1;
        retxCnt    <= '0;
      end else if (retxActive) begin
        retxCnt <= intervalDone ? '0 : cntNext[IVL_W-1:0];
      end
    end
  end
endmodule

// File: rtl/pfc_pause_dp.sv
module pfc_pause_dp
  import pfc_pkg::*;
#(
  parameter int QUANTA_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  pfcStrobes_t         strobes,
  input  logic                rxPauseValid,
  input  logic [QUANTA_W-1:0] rxPauseQuanta,
  input  logic                quantaTick,
  input  logic [QUANTA_W-1:0] cfgSendQuanta,
  output logic                txHold,
  output logic                pauseSendReq,
  output logic [QUANTA_W-1:0] pauseSendQuanta
);
  logic [QUANTA_W-1:0] pauseCount;
  logic                anyFire;

  assign anyFire = strobes.threshFire | strobes.retxFire | strobes.extFire;
  assign txHold  = pauseCount != '0;

  // Receive-side countdown: a fresh load wins over a tick
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pauseCount <= '0;
    end else if (rxPauseValid) begin
      pauseCount <= rxPauseQuanta;
    end else if (quantaTick && txHold) begin
      pauseCount <= pauseCount - QUANTA_W'(1);
    end
  end

  // Transmit-side request register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pauseSendReq    <= 1'b0;
      pauseSendQuanta <= '0;
    end else begin
      pauseSendReq <= anyFire;
      if (anyFire) pauseSendQuanta <= cfgSendQuanta;
    end
  end
endmodule

// File: rtl/pause_flow_ctrl.sv
module pause_flow_ctrl
  import pfc_pkg::*;
#(
  parameter int QUANTA_W = 16,
  parameter int FILL_W   = 13,
  parameter int IVL_W    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxPauseValid,
  input  logic [QUANTA_W-1:0] rxPauseQuanta,
  input  logic                quantaTick,
  input  logic [FILL_W-1:0]   fillLevel,
  input  logic [FILL_W-1:0]   fillThresh,
  input  logic [IVL_W-1:0]    retxInterval,
  input  logic                cfgThreshEn,
  input  logic                cfgRetxEn,
  input  logic                cfgExtEn,
  input  logic                extPauseReq,
  input  logic [QUANTA_W-1:0] cfgSendQuanta,
  output logic                txHold,
  output logic                pauseSendReq,
  output logic [QUANTA_W-1:0] pauseSendQuanta
);
  pfcStrobes_t strobes;

  pfc_trigger_ctl #(.FILL_W(FILL_W), .IVL_W(IVL_W)) ctl_i (
    .clk(clk), .rstN(rstN), .fillLevel(fillLevel), .fillThresh(fillThresh),
    .retxInterval(retxInterval), .cfgThreshEn(cfgThreshEn),
    .cfgRetxEn(cfgRetxEn), .cfgExtEn(cfgExtEn), .extPauseReq(extPauseReq),
    .strobes(strobes)
  );

  pfc_pause_dp #(.QUANTA_W(QUANTA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rxPauseValid(rxPauseValid),
    .rxPauseQuanta(rxPauseQuanta), .quantaTick(quantaTick),
    .cfgSendQuanta(cfgSendQuanta), .txHold(txHold),
    .pauseSendReq(pauseSendReq), .pauseSendQuanta(pauseSendQuanta)
  );
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
  parameter int QUANTA_W = 16,
  parameter int FILL_W   = 13,
  parameter int IVL_W    = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                rxPauseValid,
  input logic [QUANTA_W-1:0] rxPauseQuanta,
  input logic                quantaTick,
  input logic [FILL_W-1:0]   fillLevel,
  input logic [FILL_W-1:0]   fillThresh,
  input logic [IVL_W-1:0]    retxInterval,
  input logic                cfgThreshEn,
  input logic                cfgRetxEn,
  input logic                cfgExtEn,
  input logic                extPauseReq,
  input logic [QUANTA_W-1:0] cfgSendQuanta,
  input logic                txHold,
  input logic                pauseSendReq,
  input logic [QUANTA_W-1:0] pauseSendQuanta
);
  // R1
  pause_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxPauseValid && (rxPauseQuanta != '0) |=> txHold);
  // R2
  zero_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxPauseValid && (rxPauseQuanta == '0) |=> !txHold);
  // R3
  hold_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    txHold && !rxPauseValid && !quantaTick |=> txHold);
  // R3
  no_spont_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txHold && !rxPauseValid |=> !txHold);
  // R7
  ext_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgExtEn && extPauseReq && !$past(extPauseReq) |=> pauseSendReq);
  // R8
  all_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgThreshEn && !cfgRetxEn && !cfgExtEn |=> !pauseSendReq);
  // R6
  below_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillLevel <= fillThresh) && !(cfgExtEn && extPauseReq) |=> !pauseSendReq);
  // R9
  quanta_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    pauseSendReq |-> pauseSendQuanta == $past(cfgSendQuanta));
  // R10
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reset_out_chk: assert (!pauseSendReq || $past(!rstN) == 1'b0)
        else $error("R10 request during reset");
    end
  end
endmodule

bind pause_flow_ctrl pfc_checker #(
  .QUANTA_W(QUANTA_W), .FILL_W(FILL_W), .IVL_W(IVL_W)
) chk_i (.*);

// File: tb/pause_flow_ctrl_tb.sv
module pause_flow_ctrl_tb_top;
  localparam int QW = 16;
  localparam int FW = 13;
  localparam int IW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rxPauseValid = 1'b0;
  logic [QW-1:0] rxPauseQuanta = '0;
  logic          quantaTick = 1'b0;
  logic [FW-1:0] fillLevel = '0;
  logic [FW-1:0] fillThresh = 13'd100;
  logic [IW-1:0] retxInterval = '0;
  logic          cfgThreshEn = 1'b0;
  logic          cfgRetxEn = 1'b0;
  logic          cfgExtEn = 1'b0;
  logic          extPauseReq = 1'b0;
  logic [QW-1:0] cfgSendQuanta = 16'h0ABC;
  logic          txHold;
  logic          pauseSendReq;
  logic [QW-1:0] pauseSendQuanta;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit modelCheckOn = 1'b0;
  string phase = "R10";

  pause_flow_ctrl #(.QUANTA_W(QW), .FILL_W(FW), .IVL_W(IW)) dut_i (.*);

  always #4 clk = ~clk;

  // Expected-behaviour model state, derived from the requirements
  int mCount, mCnt;
  bit mAboveQ, mExtQ, mActive, mReq;
  int mQuanta;

  function automatic bit isAbove(int fill, int thr);
    return fill > thr;
  endfunction

  function automatic bit intervalReached(bit active, bit above, int cnt, int ivl);
    return active && above && (ivl != 0) && (cnt + 1 >= ivl);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCount = 0; mCnt = 0; mAboveQ = 0; mExtQ = 0; mActive = 0;
      mReq = 0; mQuanta = 0;
    end else begin
      bit ab, thF, wrap, rtF, exF;
      ab   = isAbove(int'(fillLevel), int'(fillThresh));
      thF  = cfgThreshEn && ab && !mAboveQ;
      wrap = intervalReached(mActive, ab, mCnt, int'(retxInterval));
      rtF  = cfgThreshEn && cfgRetxEn && wrap;
      exF  = cfgExtEn && extPauseReq && !mExtQ;
      mReq = thF || rtF || exF;
      if (mReq) mQuanta = int'(cfgSendQuanta);
      if (!ab) begin mActive = 0; mCnt = 0; end
      else if (thF) begin mActive = 1; mCnt = 0; end
      else if (mActive) mCnt = wrap ? 0 : mCnt + 1;
      mAboveQ = ab;
      mExtQ = extPauseReq;
      if (rxPauseValid) mCount = int'(rxPauseQuanta);
      else if (quantaTick && mCount != 0) mCount = mCount - 1;
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (modelCheckOn && rstN) begin
      check(phase, "txHold", int'(txHold), int'(mCount != 0));
      check(phase, "pauseSendReq", int'(pauseSendReq), int'(mReq));
      if (mReq) check(phase, "pauseSendQuanta", int'(pauseSendQuanta), mQuanta);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic countPulses(int n, output int pulses);
    pulses = 0;
    repeat (n) begin
      @(negedge clk);
      if (pauseSendReq) pulses++;
    end
  endtask

  task automatic loadPause(int q);
    rxPauseQuanta = QW'(q);
    rxPauseValid = 1'b1;
    @(negedge clk);
    rxPauseValid = 1'b0;
  endtask

  initial begin
    int p;
    cyc(3);
    // R10 reset state
    check("R10", "txHold in reset", int'(txHold), 0);
    check("R10", "pauseSendReq in reset", int'(pauseSendReq), 0);
    rstN = 1'b1;
    cyc(1);
    check("R10", "txHold after reset", int'(txHold), 0);
    modelCheckOn = 1'b1;

    // R1 load
    phase = "R1";
    loadPause(20);
    check("R1", "hold after load", int'(txHold), 1);
    cyc(5);
    check("R1", "hold without ticks", int'(txHold), 1);

    // R2 zero clears immediately
    phase = "R2";
    loadPause(0);
    check("R2", "hold after zero", int'(txHold), 0);

    // R3 exact countdown of 3
    phase = "R3";
    loadPause(3);
    quantaTick = 1'b1; cyc(2);
    check("R3", "hold after 2 of 3 ticks", int'(txHold), 1);
    cyc(1); quantaTick = 1'b0;
    check("R3", "hold after 3 of 3 ticks", int'(txHold), 0);
    // load with simultaneous tick: load wins
    quantaTick = 1'b1; rxPauseQuanta = 16'd1; rxPauseValid = 1'b1;
    cyc(1); rxPauseValid = 1'b0; quantaTick = 1'b0;
    check("R3", "load beats tick", int'(txHold), 1);
    quantaTick = 1'b1; cyc(1); quantaTick = 1'b0;
    check("R3", "one tick expires 1", int'(txHold), 0);

    // R4 threshold edge only, equal not above
    phase = "R4";
    cfgThreshEn = 1'b1; fillThresh = 13'd100; fillLevel = 13'd100;
    countPulses(5, p);
    check("R4", "pulses at equal fill", p, 0);
    fillLevel = 13'd101; cfgSendQuanta = 16'h1234;
    countPulses(10, p);
    check("R4", "pulses while above", p, 1);

    // R5 retransmission every 4 cycles
    phase = "R5";
    fillLevel = 13'd50; cyc(2);
    cfgRetxEn = 1'b1; retxInterval = 16'd4; fillLevel = 13'd200;
    countPulses(13, p);
    check("R5", "pulses over 13 cycles interval 4", p, 4);
    retxInterval = 16'd0; fillLevel = 13'd50; cyc(2); fillLevel = 13'd200;
    countPulses(12, p);
    check("R5", "interval zero pulses", p, 1);

    // R6 drop cancels timer, re-rise restarts
    phase = "R6";
    retxInterval = 16'd3; fillLevel = 13'd50; cyc(1); fillLevel = 13'd200;
    cyc(2); fillLevel = 13'd90;
    countPulses(8, p);
    check("R6", "pulses after drop", p, 0);
    fillLevel = 13'd300;
    countPulses(4, p);
    check("R6", "re-rise pulses in 4 cycles", p, 2);

    // R7 external edge
    phase = "R7";
    fillLevel = 13'd10; cyc(2);
    cfgExtEn = 1'b1; extPauseReq = 1'b1;
    countPulses(6, p);
    check("R7", "ext held high pulses", p, 1);
    extPauseReq = 1'b0; cyc(1);

    // R8 disabled sources
    phase = "R8";
    cfgThreshEn = 1'b0; cfgRetxEn = 1'b0; cfgExtEn = 1'b0;
    fillLevel = 13'd900; extPauseReq = 1'b1;
    countPulses(8, p);
    check("R8", "pulses all disabled", p, 0);
    extPauseReq = 1'b0; fillLevel = 13'd10; cyc(1);

    // R9 coincident triggers make one strobe with the sampled value
    phase = "R9";
    cfgThreshEn = 1'b1; cfgExtEn = 1'b1; cfgSendQuanta = 16'h7777;
    fillLevel = 13'd500; extPauseReq = 1'b1;
    @(negedge clk);
    cfgSendQuanta = 16'h0001;
    check("R9", "strobe after coincident triggers", int'(pauseSendReq), 1);
    check("R9", "strobe value", int'(pauseSendQuanta), 16'h7777);
    cyc(1);
    check("R9", "single strobe", int'(pauseSendReq), 0);
    extPauseReq = 1'b0;

    // Random mixed traffic against the model
    phase = "R3,R5,R9 random";
    void'($urandom(32'd2024));
    for (int i = 0; i < 4000; i++) begin
      if (i % 250 == 0) begin
        cfgThreshEn  = 1'($urandom_range(0, 1));
        cfgRetxEn    = 1'($urandom_range(0, 1));
        cfgExtEn     = 1'($urandom_range(0, 1));
        retxInterval = IW'($urandom_range(0, 6));
      end
      fillLevel     = FW'($urandom_range(95, 106));
      quantaTick    = ($urandom_range(0, 3) == 0);
      rxPauseValid  = ($urandom_range(0, 15) == 0);
      rxPauseQuanta = QW'($urandom_range(0, 12));
      extPauseReq   = ($urandom_range(0, 5) == 0);
      cfgSendQuanta = QW'($urandom);
      @(negedge clk);
    end
    rxPauseValid = 1'b0;
    cyc(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule